// File: doc/BRIEF.md
# PATA PIO Bus Cycle Generator

This block turns single host requests into programmed-I/O cycles on a parallel ATA cable. A host presents an address, a direction, a width flag and write data together with a one-clock start strobe. The engine then drives the two chip selects, the 3-bit device register address, the read or write strobe and, for writes, the 16-bit data bus. For reads it returns the captured data, and it signals completion with a one-clock done pulse.

All cycle timing comes from four parameters: the clock period, the address setup time, the strobe active time and the minimum cycle time, all given in nanoseconds. These are turned into clock counts when the design is elaborated. The setup count receives one extra clock so that ringing on the cable can settle. The total cycle is lengthened whenever fewer than two recovery clocks would remain after the strobe. The defaults match the slowest PIO timing (70/290/600 ns) at a 10 ns clock.

Register addressing uses even host addresses only, so 8-bit register traffic always travels on the low data byte. The top host address bit selects between the command block and the control block.

Top module: `pata_pio_engine`

## Requirements
- R1: The clock counts are derived by rounding up. SETUP = ceil(SETUP_NS/CLK_NS)+1, PULSE = ceil(PULSE_NS/CLK_NS) and CYCLE = ceil(CYCLE_NS/CLK_NS). With the defaults (10, 70, 290, 600) this gives 8, 29 and 60.
- R2: If CYCLE < SETUP+PULSE+2, the total cycle becomes SETUP+PULSE+2. With 10/30/80/100 ns this gives SETUP=4, PULSE=8 and a cycle of 14.
- R3: A request is accepted on a rising clock edge where `req_start` is high and the engine is idle. The next clock is cycle index 0. The selected chip select is low for indices 1 through CYCLE-2.
- R4: The strobe is low for indices SETUP through SETUP+PULSE-1. A read uses `ata_dior_n` and a write uses `ata_diow_n`, with identical timing for both.
- R5: If the top address bit `req_addr[4]` is 0, the access goes to the command block: `ata_cs0_n` is low and `ata_cs1_n` is high. If it is 1, the access goes to the control block and the two are reversed. `ata_da` equals `req_addr[3:1]`, and `req_addr[0]` has no effect.
- R6: Read data is the bus value at the clock edge that ends the last strobe clock. A 16-bit read returns the full bus. An 8-bit read returns {8'h00, bus[7:0]}. `req_rdata` holds this value until the next read completes.
- R7: During a write, the engine drives `ata_dd` from index 1 to the end of the cycle. A 16-bit write drives `req_wdata`. An 8-bit write drives {8'h00, req_wdata[7:0]}.
- R8: While `ata_iordy` is low during the last strobe clock, the strobe, the chip select and every later event are delayed by one clock for each such clock.
- R9: `req_done` is high for exactly one clock, at the final index of the cycle (CYCLE-1 plus any wait clocks). A `req_start` that arrives while busy is ignored.
- R10: After reset, and whenever the engine is idle, both chip selects and both strobes are high, the engine does not drive the data bus, and `req_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_start | input | 1 | Request strobe, taken only while idle |
| req_addr | input | ADDR_W | Host address: top bit selects the block, [3:1] the register |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit, 0 = 8-bit on the low byte |
| req_wdata | input | 16 | Write data |
| req_done | output | 1 | One-clock completion pulse |
| req_rdata | output | 16 | Last read result |
| ata_cs0_n | output | 1 | Command block select, active low |
| ata_cs1_n | output | 1 | Control block select, active low |
| ata_da | output | 3 | Device register address |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_dd | inout | 16 | Device data bus |
| ata_iordy | input | 1 | Device ready; low stretches the strobe |

## Verification
The bench exercises reads and writes of both widths, in both register blocks, and with odd and even host addresses. These cases separate the chip-select decode, the low-byte packing and the ignored address bit zero.

A second instance runs with timing short enough that the two-clock recovery floor takes effect. This distinguishes the adjusted cycle from the raw one.

Stretched transfers hold the ready input low for several clocks, which shows whether every later event moves with the wait. The device changes its data on the last strobe clock only, so the result shows whether the capture happens at the strobe's rising edge.

A start request issued in the middle of a cycle confirms that the running transfer is left unchanged.

// File: rtl/pata_pio_engine.sv
`timescale 1ns/1ps
module pata_pio_engine #(
  parameter int CLK_NS   = 10,
  parameter int SETUP_NS = 70,
  parameter int PULSE_NS = 290,
  parameter int CYCLE_NS = 600,
  parameter int ADDR_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_start,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic [15:0]       req_wdata,
  output logic              req_done,
  output logic [15:0]       req_rdata,
  output logic              ata_cs0_n,
  output logic              ata_cs1_n,
  output logic [2:0]        ata_da,
  output logic              ata_dior_n,
  output logic              ata_diow_n,
  inout  wire  [15:0]       ata_dd,
  input  logic              ata_iordy
);
  localparam int SET_C   = (SETUP_NS + CLK_NS - 1) / CLK_NS + 1;
  localparam int PUL_C   = (PULSE_NS + CLK_NS - 1) / CLK_NS;
  localparam int CYC_RAW = (CYCLE_NS + CLK_NS - 1) / CLK_NS;
  localparam int ACT_C   = SET_C + PUL_C;
  localparam int CYC_C   = (CYC_RAW < ACT_C + 2) ? ACT_C + 2 : CYC_RAW;
  localparam int CW      = $clog2(CYC_C + 1);

  localparam logic [CW-1:0] T_ONE  = CW'(1);
  localparam logic [CW-1:0] T_SET  = CW'(SET_C);
  localparam logic [CW-1:0] T_SPE  = CW'(ACT_C - 1);
  localparam logic [CW-1:0] T_CSE  = CW'(CYC_C - 2);
  localparam logic [CW-1:0] T_LAST = CW'(CYC_C - 1);

  logic              busy;
  logic [CW-1:0]     t;
  logic [ADDR_W-1:0] a_q;
  logic              wr_q, wide_q;
  logic [15:0]       wd_q, rd_q;

  wire cs_win = busy && t >= T_ONE && t <= T_CSE;
  wire strobe = busy && t >= T_SET && t <= T_SPE;
  wire at_end = strobe && t == T_SPE;
  wire stall  = at_end && !ata_iordy;
  wire region = a_q[ADDR_W-1];
  wire dd_oe  = busy && wr_q && t >= T_ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      t      <= '0;
      a_q    <= '0;
      wr_q   <= 1'b0;
      wide_q <= 1'b0;
      wd_q   <= '0;
      rd_q   <= '0;
    end else begin
      if (!busy) begin
        if (req_start) begin
          busy   <= 1'b1;
          t      <= '0;
          a_q    <= req_addr;
          wr_q   <= req_write;
          wide_q <= req_wide;
          wd_q   <= req_wdata;
        end
      end else if (!stall) begin
        if (t == T_LAST) busy <= 1'b0;
        else             t    <= t + 1'b1;
      end
      if (at_end && ata_iordy && !wr_q)
        rd_q <= wide_q ? ata_dd : {8'h00, ata_dd[7:0]};
    end
  end

  assign ata_cs0_n  = !(cs_win && !region);
  assign ata_cs1_n  = !(cs_win && region);
  assign ata_da     = a_q[3:1];
  assign ata_dior_n = !(strobe && !wr_q);
  assign ata_diow_n = !(strobe && wr_q);
  assign ata_dd     = dd_oe ? (wide_q ? wd_q : {8'h00, wd_q[7:0]}) : 16'hzzzz;
  assign req_done   = busy && t == T_LAST;
  assign req_rdata  = rd_q;

  // R4
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ata_dior_n && !ata_diow_n));
  // R3
  strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ata_dior_n || !ata_diow_n) |-> (!ata_cs0_n || !ata_cs1_n));
  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> !req_done);
  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ata_cs0_n || !ata_cs1_n) |=> (ata_cs0_n && ata_cs1_n) || $stable(ata_da));
  // R7
  no_drive_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ata_dior_n |-> !dd_oe);
  // R8
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ata_dior_n && !ata_iordy && $past(!ata_dior_n)) |=> !ata_dior_n);
endmodule

// File: tb/pata_pio_engine_tb.sv
`timescale 1ns/1ps
module pata_pio_engine_tb_top;
  logic clk = 0;
  always #5 clk = ~clk;
  logic rst_n = 0;

  logic        req_start = 0, sel = 0;
  logic [4:0]  req_addr = 0;
  logic        req_write = 0, req_wide = 0, iordy = 1;
  logic [15:0] req_wdata = 0;
  logic        dev_oe = 0;
  logic [15:0] dev_val = 0;

  wire a_start = req_start && !sel;
  wire b_start = req_start && sel;
  wire [15:0] dd_a, dd_b;
  assign dd_a = (dev_oe && !sel) ? dev_val : 16'hzzzz;
  assign dd_b = (dev_oe && sel) ? dev_val : 16'hzzzz;

  logic a_done, a_cs0, a_cs1, a_rd, a_wr, b_done, b_cs0, b_cs1, b_rd, b_wr;
  logic [2:0] a_da, b_da;
  logic [15:0] a_rdata, b_rdata;

  pata_pio_engine dut_i (.clk(clk), .rst_n(rst_n), .req_start(a_start), .req_addr(req_addr),
    .req_write(req_write), .req_wide(req_wide), .req_wdata(req_wdata), .req_done(a_done),
    .req_rdata(a_rdata), .ata_cs0_n(a_cs0), .ata_cs1_n(a_cs1), .ata_da(a_da),
    .ata_dior_n(a_rd), .ata_diow_n(a_wr), .ata_dd(dd_a), .ata_iordy(iordy));

  pata_pio_engine #(.CLK_NS(10), .SETUP_NS(30), .PULSE_NS(80), .CYCLE_NS(100)) dut2_i (
    .clk(clk), .rst_n(rst_n), .req_start(b_start), .req_addr(req_addr),
    .req_write(req_write), .req_wide(req_wide), .req_wdata(req_wdata), .req_done(b_done),
    .req_rdata(b_rdata), .ata_cs0_n(b_cs0), .ata_cs1_n(b_cs1), .ata_da(b_da),
    .ata_dior_n(b_rd), .ata_diow_n(b_wr), .ata_dd(dd_b), .ata_iordy(iordy));

  wire [8:0]  obs   = sel ? {b_cs0, b_cs1, b_rd, b_wr, b_da, b_done, 1'b0}
                          : {a_cs0, a_cs1, a_rd, a_wr, a_da, a_done, 1'b0};
  wire [15:0] obs_rd = sel ? b_rdata : a_rdata;
  wire [15:0] obs_dd = sel ? dd_b : dd_a;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [15:0] last_rd [2];

  function automatic int cdiv(int a, int b);
    return (a + b - 1) / b;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle_check(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      // R10: selects and strobes high, no done; R6: read result held
      chk("R10 idle", {7'd0, obs[8:5], obs[1]}, {7'd0, 4'b1111, 1'b0});
      chk("R6 hold", obs_rd, last_rd[sel]);
    end
  endtask

  task automatic xfer(bit s, logic [4:0] addr, bit wr, bit wide, logic [15:0] wd,
                      logic [15:0] rv, int w, bit poke);
    int st, pu, cy, spe, last;
    // R1 conversion, R2 recovery floor
    st = s ? cdiv(30, 10) + 1 : cdiv(70, 10) + 1;
    pu = s ? cdiv(80, 10) : cdiv(290, 10);
    cy = s ? cdiv(100, 10) : cdiv(600, 10);
    if (cy < st + pu + 2) cy = st + pu + 2;
    spe = st + pu - 1;
    last = cy - 1 + w;
    @(negedge clk);
    sel = s; req_addr = addr; req_write = wr; req_wide = wide; req_wdata = wd;
    req_start = 1;
    @(posedge clk);
    for (int k = 0; k <= last; k++) begin
      bit csw, stb;
      logic [8:0] exp;
      @(negedge clk);
      if (k == 0) req_start = 0;
      if (poke && k == 3) begin req_start = 1; req_addr = ~addr; req_write = ~wr; end
      if (poke && k == 4) req_start = 0;
      iordy = !(w > 0 && k >= spe && k < spe + w);
      dev_oe = !wr && k >= st && k <= spe + w;
      dev_val = (k == spe + w) ? rv : ~rv;
      #1;
      csw = k >= 1 && k <= cy - 2 + w;
      stb = k >= st && k <= spe + w;
      exp = {!(csw && !addr[4]), !(csw && addr[4]), !(stb && !wr), !(stb && wr),
             addr[3:1], k == last, 1'b0};
      // R3 R4 R5 R8 R9 per-clock comparison
      chk($sformatf("R3/R4/R5/R8/R9 k=%0d", k), {7'd0, obs}, {7'd0, exp});
      if (wr && k >= 1)  // R7
        chk($sformatf("R7 drive k=%0d", k), obs_dd, wide ? wd : {8'h00, wd[7:0]});
      if (!wr && k == last) begin  // R6
        last_rd[s] = wide ? rv : {8'h00, rv[7:0]};
        chk("R6 capture", obs_rd, last_rd[s]);
      end
    end
    dev_oe = 0; iordy = 1;
    req_addr = addr; req_write = wr;
    idle_check(3);
  endtask

  initial begin
    last_rd[0] = 0; last_rd[1] = 0;
    repeat (3) @(negedge clk);
    sel = 0; idle_check(1);
    sel = 1; idle_check(1);
    rst_n = 1;
    xfer(0, 5'h04, 0, 1, 16'h0000, 16'hA55A, 0, 0);
    xfer(0, 5'h1C, 0, 0, 16'h0000, 16'h3C7E, 0, 0);
    xfer(0, 5'h00, 1, 1, 16'hBEEF, 16'h0000, 0, 0);
    xfer(0, 5'h1D, 1, 0, 16'h12AB, 16'h0000, 0, 0);
    xfer(0, 5'h0E, 0, 1, 16'h0000, 16'h1234, 5, 0);
    xfer(0, 5'h0B, 1, 1, 16'hC0DE, 16'h0000, 3, 1);
    xfer(1, 5'h02, 0, 0, 16'h0000, 16'h99F1, 0, 0);
    xfer(1, 5'h1A, 1, 1, 16'h5AA5, 16'h0000, 2, 1);
    xfer(1, 5'h07, 0, 1, 16'h0000, 16'h8001, 4, 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule